// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This controller collects a set of interrupt request lines that are not tied to its clock, brings each one into the clock domain, and drops the ones that software has switched off. From what remains it picks the most urgent request and raises a single interrupt toward the processor. With that interrupt it gives the number of the chosen source and a branch target address made from a programmable base plus four times the source number. The processor can therefore jump straight to a handler for each source, with no common dispatcher.

The processor answers with an acknowledge pulse. The controller then marks the presented source as in service. That source is left out of the ranking until an end-of-service pulse arrives, so a request line that is still high cannot retrigger its own handler. Other enabled sources are still presented while the handler runs. Only one source can be in service at a time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A request line held high is synchronized by two flip-flops and then registered at the output. If the line rises between two clock edges and nothing outranks it, `irqOut` goes high after the third rising edge that follows, and not before.
- R2: `maskRdata` returns the last value written through `maskWe`/`maskWdata`, and it is all zeros after reset. Bit i = 1 enables source i. A source whose bit is 0 is never presented, whatever its line does.
- R3: Among enabled, synchronized and not-inhibited requests, the lowest index wins. Source 0 has the highest priority.
- R4: While `irqOut` is high, `srcId` is the winning index and `vecAddr` equals base + 4 × `srcId`. The base is the last value written through `baseWe`/`baseWdata` and is 0 after reset. While `irqOut` is low, `srcId` is 0 and `vecAddr` equals the base.
- R5: An `ack` sampled while `irqOut` is high and no source is in service sets `inServiceValid` at that edge, with `inServiceId` equal to the `srcId` presented at that edge.
- R6: From the acknowledging edge onward, the in-service source is excluded from ranking. The next-ranked pending source, if any, is presented at that same edge.
- R7: An `eoi` sampled while a source is in service clears `inServiceValid` at that edge, and the source may be presented again from that edge. An `eoi` while nothing is in service has no effect.
- R8: An `ack` sampled while `irqOut` is low, or while a source is already in service, is ignored: `inServiceValid` and `inServiceId` keep their values.
- R9: After reset, `irqOut`, `srcId`, `vecAddr`, `inServiceValid`, `inServiceId` and `maskRdata` are all zero.
- R10: A request pulse that rises and falls between two rising clock edges is not seen by the controller and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_SRC | Raw request lines, not synchronous to clk |
| maskWe | input | 1 | Write strobe for the enable register |
| maskWdata | input | NUM_SRC | New enable value; bit i = 1 enables source i |
| maskRdata | output | NUM_SRC | Current enable register contents |
| baseWe | input | 1 | Write strobe for the vector base register |
| baseWdata | input | ADDR_W | New vector base address |
| ack | input | 1 | Processor takes the presented interrupt |
| eoi | input | 1 | Processor finished the handler of the in-service source |
| irqOut | output | 1 | Interrupt request to the processor |
| srcId | output | IDX_W | Index of the presented source |
| vecAddr | output | ADDR_W | Handler address: base + 4 × srcId |
| inServiceValid | output | 1 | A source is currently in service |
| inServiceId | output | IDX_W | Index of the in-service source |

## Verification
The hardest state to reach from the ports needs three things at once: a source in service, its own line still held high, and a lower-ranked line also pending. Only in that state can the bench show the inhibit switching the presentation at the acknowledging edge, an `ack` arriving while busy being dropped, and `eoi` handing the same source straight back. The directed part raises two lines, waits for synchronization, then acknowledges, repeats the ack, and ends service while both lines are still high. A long pseudo-random phase then mixes line toggles, enable writes, acks and eois. A behavioural model checks every cycle of it, so many orderings of ack and eoi against changing requests are covered.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Strobes from the service control to the datapath
  typedef struct packed {
    logic latchSvc;   // capture the presented source as in service
    logic clearSvc;   // end of service accepted
  } svc_strobe_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], asyncIn[b]};
      end
      assign syncOut[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_vec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack,
  input  logic        eoi,
  input  logic        irqOut,
  output svc_strobe_t strobes,
  output logic        svcValid,
  output logic        svcValidNext
);

  always_comb begin
    strobes.latchSvc = ack && irqOut && !svcValid;
    strobes.clearSvc = eoi && svcValid;
  end

  always_comb begin
    svcValidNext = svcValid;
    if (strobes.clearSvc)      svcValidNext = 1'b0;
    else if (strobes.latchSvc) svcValidNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svcValid <= 1'b0;
    else        svcValid <= svcValidNext;
  end

  // R5: an accepted ack puts a source in service
  p_ack_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irqOut && !svcValid) |=> svcValid);

  // R7: end of service clears the in-service state
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && svcValid) |=> !svcValid);

  // R8: while busy and without eoi the state holds
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svcValid && !eoi) |=> svcValid);

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int ADDR_W    = 32,
  parameter int VEC_SHIFT = 2,
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] syncReq,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskWdata,
  input  logic               baseWe,
  input  logic [ADDR_W-1:0]  baseWdata,
  input  svc_strobe_t        strobes,
  input  logic               svcValid,
  input  logic               svcValidNext,
  output logic [NUM_SRC-1:0] enableReg,
  output logic               irqOut,
  output logic [IDX_W-1:0]   srcId,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [IDX_W-1:0]   svcId
);

  logic [ADDR_W-1:0]  baseReg;
  logic [IDX_W-1:0]   svcIdNext;
  logic [NUM_SRC-1:0] inhibit;
  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   winIdx;
  logic               winFound;
  logic [ADDR_W-1:0]  winVec;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableReg <= '0;
      baseReg   <= '0;
    end else begin
      if (maskWe) enableReg <= maskWdata;
      if (baseWe) baseReg   <= baseWdata;
    end
  end

  // In-service source index
  assign svcIdNext = strobes.latchSvc ? srcId : svcId;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svcId <= '0;
    else        svcId <= svcIdNext;
  end

  // Inhibit uses the next in-service state so the acked source drops at once
  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_inh
      assign inhibit[s] = svcValidNext && (svcIdNext == IDX_W'(s));
    end
  endgenerate

  assign eligible = syncReq & enableReg & ~inhibit;

  // Fixed-priority network: lowest index wins
  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winIdx   = IDX_W'(i);
        winFound = 1'b1;
      end
    end
  end

  assign winVec = baseReg + (ADDR_W'(winIdx) << VEC_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqOut  <= 1'b0;
      srcId   <= '0;
      vecAddr <= '0;
    end else begin
      irqOut  <= winFound;
      srcId   <= winIdx;
      vecAddr <= winVec;
    end
  end

  // R6: the presented source is never the one in service
  p_no_self_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && svcValid) |-> (srcId != svcId));

  // R2: a presented source was enabled when it was ranked
  p_only_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> ((($past(enableReg) >> srcId) & NUM_SRC'(1)) != '0));

  // R8: the in-service index changes only on an accepted ack
  p_svcid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.latchSvc |=> $stable(svcId));

  // R4: nothing presented means index zero
  p_idle_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irqOut |-> (srcId == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_SHIFT   = 2,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskWdata,
  output logic [NUM_SRC-1:0] maskRdata,
  input  logic               baseWe,
  input  logic [ADDR_W-1:0]  baseWdata,
  input  logic               ack,
  input  logic               eoi,
  output logic               irqOut,
  output logic [IDX_W-1:0]   srcId,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               inServiceValid,
  output logic [IDX_W-1:0]   inServiceId
);

  logic [NUM_SRC-1:0] syncReq;
  svc_strobe_t        strobes;
  logic               svcValidNext;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (irqLines),
    .syncOut (syncReq)
  );

  irq_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack          (ack),
    .eoi          (eoi),
    .irqOut       (irqOut),
    .strobes      (strobes),
    .svcValid     (inServiceValid),
    .svcValidNext (svcValidNext)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT)) i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .syncReq      (syncReq),
    .maskWe       (maskWe),
    .maskWdata    (maskWdata),
    .baseWe       (baseWe),
    .baseWdata    (baseWdata),
    .strobes      (strobes),
    .svcValid     (inServiceValid),
    .svcValidNext (svcValidNext),
    .enableReg    (maskRdata),
    .irqOut       (irqOut),
    .srcId        (srcId),
    .vecAddr      (vecAddr),
    .svcId        (inServiceId)
  );

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

  localparam int NS = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irqLines = '0;
  logic          maskWe = 1'b0;
  logic [NS-1:0] maskWdata = '0;
  logic [NS-1:0] maskRdata;
  logic          baseWe = 1'b0;
  logic [AW-1:0] baseWdata = '0;
  logic          ack = 1'b0;
  logic          eoi = 1'b0;
  logic          irqOut;
  logic [2:0]    srcId;
  logic [AW-1:0] vecAddr;
  logic          inServiceValid;
  logic [2:0]    inServiceId;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines),
    .maskWe(maskWe), .maskWdata(maskWdata), .maskRdata(maskRdata),
    .baseWe(baseWe), .baseWdata(baseWdata), .ack(ack), .eoi(eoi),
    .irqOut(irqOut), .srcId(srcId), .vecAddr(vecAddr),
    .inServiceValid(inServiceValid), .inServiceId(inServiceId)
  );

  // Behavioural reference model, advanced on each rising edge
  int unsigned mLines[$];   // line samples in flight through synchronization
  int unsigned mEn, mBase;
  bit          mIrq, mSvcV;
  int unsigned mId, mVec, mSvcId;

  always @(posedge clk) begin
    if (!rst_n) begin
      mLines = '{0, 0};
      mEn = 0; mBase = 0; mIrq = 0; mSvcV = 0;
      mId = 0; mVec = 0; mSvcId = 0;
    end else begin
      bit nV; int unsigned nId; int unsigned cand; bit found; int unsigned w;
      nV = mSvcV; nId = mSvcId;
      if (eoi && mSvcV) nV = 0;
      else if (ack && mIrq && !mSvcV) begin nV = 1; nId = mId; end
      cand = mLines[0] & mEn;
      if (nV) cand = cand & ~(32'd1 << nId);
      found = 0; w = 0;
      for (int i = 0; i < NS; i++)
        if (!found && cand[i]) begin found = 1; w = i; end
      mIrq = found; mId = w; mVec = mBase + 4 * w;
      void'(mLines.pop_front());
      mLines.push_back(int'(irqLines));
      if (maskWe) mEn = maskWdata;
      if (baseWe) mBase = baseWdata;
      mSvcV = nV; mSvcId = nId;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  bit modelOn = 0;
  always @(negedge clk) begin
    if (modelOn && rst_n) begin
      check(irqOut == mIrq, "R1 irqOut vs model", irqOut, mIrq);
      check(srcId == mId[2:0], "R3 srcId vs model", srcId, mId);
      check(vecAddr == mVec, "R4 vecAddr vs model", vecAddr, mVec);
      check(inServiceValid == mSvcV, "R5 inServiceValid vs model", inServiceValid, mSvcV);
      check(inServiceId == mSvcId[2:0], "R6 inServiceId vs model", inServiceId, mSvcId);
      check(maskRdata == mEn[NS-1:0], "R2 maskRdata vs model", maskRdata, mEn);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    modelOn = 1;
    cyc(1);
    // R9: reset state
    check(!irqOut && srcId == 0 && vecAddr == 0 && !inServiceValid &&
          inServiceId == 0 && maskRdata == 0, "R9 reset state",
          {irqOut, srcId, inServiceValid, inServiceId, maskRdata}, 0);

    // R2: enable written and read back; line 3 ignored while disabled
    irqLines = 8'h08; cyc(5);
    check(!irqOut, "R2 disabled source ignored", irqOut, 0);
    irqLines = 0;
    baseWe = 1; baseWdata = 32'h1000; maskWe = 1; maskWdata = 8'hFF; cyc(1);
    baseWe = 0; maskWe = 0; cyc(4);
    check(maskRdata == 8'hFF, "R2 enable readback", maskRdata, 8'hFF);

    // R1: line 3 rises mid-cycle; visible after the third edge
    irqLines = 8'h08; cyc(2);
    check(!irqOut, "R1 not yet after two edges", irqOut, 0);
    cyc(1);
    check(irqOut && srcId == 3, "R1 presented after three edges", srcId, 3);
    check(vecAddr == 32'h100C, "R4 vector for source 3", vecAddr, 32'h100C);

    // R3: line 1 outranks line 3
    irqLines = 8'h0A; cyc(3);
    check(srcId == 1 && vecAddr == 32'h1004, "R3 lower index wins", srcId, 1);

    // R5/R6: ack takes source 1, source 3 presented at the same edge
    ack = 1; cyc(1); ack = 0;
    check(inServiceValid && inServiceId == 1, "R5 ack latches source", inServiceId, 1);
    check(irqOut && srcId == 3, "R6 in-service source skipped", srcId, 3);

    // R8: ack while busy ignored
    ack = 1; cyc(1); ack = 0;
    check(inServiceValid && inServiceId == 1, "R8 ack while busy ignored", inServiceId, 1);

    // R7: eoi releases, source 1 comes back
    eoi = 1; cyc(1); eoi = 0;
    check(!inServiceValid && srcId == 1, "R7 eoi returns source", srcId, 1);
    eoi = 1; cyc(1); eoi = 0;
    check(!inServiceValid && irqOut && srcId == 1, "R7 eoi while idle no effect", srcId, 1);

    // R2: disabling source 1 leaves source 3
    maskWe = 1; maskWdata = 8'hFD; cyc(1); maskWe = 0; cyc(1);
    check(srcId == 3, "R2 masked source skipped", srcId, 3);

    // R8: ack while nothing presented
    irqLines = 0; cyc(4);
    check(!irqOut && vecAddr == 32'h1000, "R4 idle vector is base", vecAddr, 32'h1000);
    ack = 1; cyc(1); ack = 0;
    check(!inServiceValid, "R8 ack without request ignored", inServiceValid, 0);

    // R10: a pulse between two edges is missed
    @(negedge clk); #0.5 irqLines[5] = 1'b1; #1 irqLines[5] = 1'b0;
    cyc(5);
    check(!irqOut, "R10 short pulse missed", irqOut, 0);

    // Pseudo-random phase, model compared every cycle
    begin
      int unsigned lfsr = 32'hACE1_2345;
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3:1] == 0) irqLines = lfsr[15:8];
        maskWe = (lfsr[7:4] == 0);
        maskWdata = lfsr[23:16];
        ack = lfsr[24] & lfsr[25];
        eoi = (lfsr[27:26] == 0);
        baseWe = (lfsr[31:28] == 0);
        baseWdata = {16'h0, lfsr[15:0]};
        cyc(1);
      end
      ack = 0; eoi = 0; maskWe = 0; baseWe = 0;
    end
    cyc(2);
    summary();
  end

endmodule